// File: doc/BRIEF.md
# Control endpoint status register

This block holds the control and status bits of a USB device's default control endpoint. Two agents share it. A microcontroller bus port reads and writes the status byte at one address and reads the endpoint FIFO byte count at a second address. A serial interface engine (SIE) reports its events through single-cycle strobes. Each flag has one owner side that sets or loads it and one side that clears it. The SIE-owned flags are cleared from the bus only by writing 1 to separate "serviced" bits, and those serviced bits always read back as zero.

When both sides act on the same flag in the same cycle, the setting or loading side wins, so a fresh event is never lost. The SIE receives a stall request, which is the OR of the software stall bit and the engine's own protocol-violation stall. It also receives the transmit-ready flag and the data-phase-end flag. Reads are combinational from the address. The count is a saturating 3-bit value that only the SIE can change.

Top module: `ep0_ctl_csr`

## Requirements
- R1: After reset, every flag and the byte count are 0, so both register addresses read 0x00 and all three SIE outputs are low.
- R2: The status byte reads at address 1 with out-ready at bit 0, in-ready at bit 1, forced stall at bit 2, data end at bit 3, setup abort at bit 4 and software stall at bit 5. Bits 7 and 6 always read 0. Address 2 returns the count in bits [2:0] with the upper bits 0, and any other address reads 0.
- R3: Out-ready (bit 0) becomes 1 on the cycle after `sie_out_rdy_set`. It is cleared only by a bus write to address 1 with bit 6 set. A bus write to bit 0 has no effect.
- R4: Setup abort (bit 4) becomes 1 on the cycle after `sie_setup_end_set`. It is cleared by a bus write to address 1 with bit 7 set. A bus write to bit 4 has no effect.
- R5: Every bus write to address 1 loads in-ready (bit 1) from data bit 1. `sie_in_done` clears it. If both happen in the same cycle, the bus write wins.
- R6: Forced stall (bit 2) is set by `sie_force_stall_set` and cleared by `sie_force_stall_clr`, and the set wins when both arrive together. Bus writes do not change it.
- R7: Every bus write to address 1 loads software stall (bit 5) and data end (bit 3) from data bits 5 and 3. `sie_new_setup` clears both, and a bus write in the same cycle wins.
- R8: When the SIE set strobe and the serviced-clear write land in the same cycle for out-ready or setup abort, the flag ends up 1.
- R9: `sie_stall_req` is high whenever software stall or forced stall is 1. `sie_in_rdy` and `sie_data_end` follow bits 1 and 3.
- R10: `sie_cnt_inc` adds one to the count and holds it at 7. `sie_cnt_clr` zeroes it and takes priority over an increment in the same cycle. Bus writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Bus register address |
| bus_wr | input | 1 | Bus write strobe, one cycle |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data for the current address, combinational |
| sie_out_rdy_set | input | 1 | Received packet placed in FIFO |
| sie_in_done | input | 1 | Transmit packet delivered |
| sie_force_stall_set | input | 1 | Protocol violation detected |
| sie_force_stall_clr | input | 1 | Forced stall withdrawn |
| sie_setup_end_set | input | 1 | Setup arrived before the previous transfer finished |
| sie_new_setup | input | 1 | Start of a new setup transaction |
| sie_cnt_inc | input | 1 | One byte added to the FIFO |
| sie_cnt_clr | input | 1 | FIFO emptied |
| sie_stall_req | output | 1 | Stall handshake request |
| sie_in_rdy | output | 1 | Transmit data loaded by the microcontroller |
| sie_data_end | output | 1 | Last data of the data phase handled |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled on the rising edge, and that reset is released away from a clock edge. They place no limit on how strobes combine, so any mix of set, clear and write in one cycle must obey the priority rules. The stimulus drives every input only at the falling edge. Directed sequences first place each same-cycle collision on purpose, and a long random run then fires all strobes and writes to all four low addresses at once. A behavioural model in the bench follows every cycle of both phases.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
   localparam int REG_W           = 8;
   localparam int NUM_FLAGS       = 6;
   localparam int BIT_OUT_RDY     = 0;
   localparam int BIT_IN_RDY      = 1;
   localparam int BIT_FORCE_STALL = 2;
   localparam int BIT_DATA_END    = 3;
   localparam int BIT_SETUP_END   = 4;
   localparam int BIT_SEND_STALL  = 5;
   localparam int BIT_SVC_OUT     = 6;
   localparam int BIT_SVC_SETUP   = 7;

   typedef enum logic {OWN_SIE = 1'b0, OWN_MCU = 1'b1} owner_e;

   function automatic owner_e owner_of(input int b);
      if (b == BIT_IN_RDY || b == BIT_DATA_END || b == BIT_SEND_STALL)
         return OWN_MCU;
      return OWN_SIE;
   endfunction
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_en,
   input  logic upd_val,
   input  logic clr,
   output logic q
);
   // owner update wins over the other side's clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (upd_en) q <= upd_val;
      else if (clr)    q <= 1'b0;
   end
endmodule

// File: rtl/ep0_sat_count.sv
module ep0_sat_count #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (clr)              q <= '0;
      else if (inc && q != TOP)  q <= q + 1'b1;
   end
endmodule

// File: rtl/ep0_ctl_csr.sv
module ep0_ctl_csr
   import ep0_csr_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CSR_ADDR = 1,
   parameter int CNT_ADDR = 2,
   parameter int CNT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              sie_out_rdy_set,
   input  logic              sie_in_done,
   input  logic              sie_force_stall_set,
   input  logic              sie_force_stall_clr,
   input  logic              sie_setup_end_set,
   input  logic              sie_new_setup,
   input  logic              sie_cnt_inc,
   input  logic              sie_cnt_clr,
   output logic              sie_stall_req,
   output logic              sie_in_rdy,
   output logic              sie_data_end
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (CSR_ADDR == CNT_ADDR) begin : g_err_addr_clash
      $error("status and count addresses must differ");
   end
   if (CSR_ADDR >= ADDR_SPAN || CNT_ADDR >= ADDR_SPAN) begin : g_err_addr_range
      $error("register address does not fit ADDR_W");
   end
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_err_cnt_w
      $error("CNT_W must lie in 1..REG_W");
   end

   logic                 csr_wr;
   logic [NUM_FLAGS-1:0] sie_set_v;
   logic [NUM_FLAGS-1:0] clr_v;
   logic [NUM_FLAGS-1:0] upd_en_v;
   logic [NUM_FLAGS-1:0] upd_val_v;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 unused_wdata;

   assign csr_wr       = bus_wr && (bus_addr == ADDR_W'(CSR_ADDR));
   assign unused_wdata = ^{bus_wdata[BIT_OUT_RDY], bus_wdata[BIT_FORCE_STALL],
                           bus_wdata[BIT_SETUP_END]};

   always_comb begin
      sie_set_v                   = '0;
      sie_set_v[BIT_OUT_RDY]      = sie_out_rdy_set;
      sie_set_v[BIT_FORCE_STALL]  = sie_force_stall_set;
      sie_set_v[BIT_SETUP_END]    = sie_setup_end_set;

      clr_v                       = '0;
      clr_v[BIT_OUT_RDY]          = csr_wr && bus_wdata[BIT_SVC_OUT];
      clr_v[BIT_SETUP_END]        = csr_wr && bus_wdata[BIT_SVC_SETUP];
      clr_v[BIT_FORCE_STALL]      = sie_force_stall_clr;
      clr_v[BIT_IN_RDY]           = sie_in_done;
      clr_v[BIT_DATA_END]         = sie_new_setup;
      clr_v[BIT_SEND_STALL]       = sie_new_setup;
   end

   // each flag picks its update source from its owning side
   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      if (owner_of(i) == OWN_MCU) begin : g_mcu
         assign upd_en_v[i]  = csr_wr;
         assign upd_val_v[i] = bus_wdata[i];
      end else begin : g_sie
         assign upd_en_v[i]  = sie_set_v[i];
         assign upd_val_v[i] = 1'b1;
      end
      ep0_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .upd_en  (upd_en_v[i]),
         .upd_val (upd_val_v[i]),
         .clr     (clr_v[i]),
         .q       (flag_q[i])
      );
   end

   ep0_sat_count #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sie_cnt_clr),
      .inc   (sie_cnt_inc),
      .q     (cnt_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CSR_ADDR))
         bus_rdata[NUM_FLAGS-1:0] = flag_q;
      else if (bus_addr == ADDR_W'(CNT_ADDR))
         bus_rdata[CNT_W-1:0] = cnt_q;
   end

   assign sie_stall_req = flag_q[BIT_SEND_STALL] | flag_q[BIT_FORCE_STALL];
   assign sie_in_rdy    = flag_q[BIT_IN_RDY];
   assign sie_data_end  = flag_q[BIT_DATA_END];
endmodule

// File: rtl/ep0_ctl_csr_chk.sv
module ep0_ctl_csr_chk
   import ep0_csr_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CSR_ADDR = 1,
   parameter int CNT_W    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic [REG_W-1:0]     bus_wdata,
   input logic [REG_W-1:0]     bus_rdata,
   input logic                 sie_out_rdy_set,
   input logic                 sie_force_stall_set,
   input logic                 sie_force_stall_clr,
   input logic                 sie_setup_end_set,
   input logic                 sie_new_setup,
   input logic                 sie_cnt_clr,
   input logic                 sie_stall_req,
   input logic [NUM_FLAGS-1:0] flag_q,
   input logic [CNT_W-1:0]     cnt_q
);
   logic wr_s;
   assign wr_s = bus_wr && (bus_addr == ADDR_W'(CSR_ADDR));

   p_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CSR_ADDR)) |-> (bus_rdata[7:6] == 2'b00));

   p_out_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sie_out_rdy_set |=> flag_q[BIT_OUT_RDY]);

   p_out_svc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_s && bus_wdata[BIT_SVC_OUT] && !sie_out_rdy_set) |=> !flag_q[BIT_OUT_RDY]);

   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sie_out_rdy_set && !(wr_s && bus_wdata[BIT_SVC_OUT])) |=> $stable(flag_q[BIT_OUT_RDY]));

   p_se_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sie_setup_end_set |=> flag_q[BIT_SETUP_END]);

   p_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_s |=> (flag_q[BIT_IN_RDY] == $past(bus_wdata[BIT_IN_RDY])));

   p_fs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sie_force_stall_set && !sie_force_stall_clr) |=> $stable(flag_q[BIT_FORCE_STALL]));

   p_setup_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sie_new_setup && !wr_s) |=> (!flag_q[BIT_SEND_STALL] && !flag_q[BIT_DATA_END]));

   p_stall_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sie_stall_req) |-> $past(sie_force_stall_set || (wr_s && bus_wdata[BIT_SEND_STALL])));

   p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q == '1) && !sie_cnt_clr) |=> (cnt_q == '1));

   p_cnt_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sie_cnt_clr |=> (cnt_q == '0));
endmodule

bind ep0_ctl_csr ep0_ctl_csr_chk #(
   .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .CNT_W(CNT_W)
) u_chk (
   .clk                 (clk),
   .rst_n               (rst_n),
   .bus_addr            (bus_addr),
   .bus_wr              (bus_wr),
   .bus_wdata           (bus_wdata),
   .bus_rdata           (bus_rdata),
   .sie_out_rdy_set     (sie_out_rdy_set),
   .sie_force_stall_set (sie_force_stall_set),
   .sie_force_stall_clr (sie_force_stall_clr),
   .sie_setup_end_set   (sie_setup_end_set),
   .sie_new_setup       (sie_new_setup),
   .sie_cnt_clr         (sie_cnt_clr),
   .sie_stall_req       (sie_stall_req),
   .flag_q              (flag_q),
   .cnt_q               (cnt_q)
);

// File: tb/ep0_ctl_csr_tb.sv
`timescale 1ns/1ps
module ep0_ctl_csr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic out_set = 0, in_done = 0, fs_set = 0, fs_clr = 0, se_set = 0, new_setup = 0;
   logic cnt_inc = 0, cnt_clr = 0;
   logic stall_req, in_rdy, data_end;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ep0_ctl_csr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sie_out_rdy_set(out_set), .sie_in_done(in_done),
      .sie_force_stall_set(fs_set), .sie_force_stall_clr(fs_clr),
      .sie_setup_end_set(se_set), .sie_new_setup(new_setup),
      .sie_cnt_inc(cnt_inc), .sie_cnt_clr(cnt_clr),
      .sie_stall_req(stall_req), .sie_in_rdy(in_rdy), .sie_data_end(data_end)
   );

   // behavioural reference model
   int m_out, m_in, m_fs, m_de, m_se, m_ss, m_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out = 0; m_in = 0; m_fs = 0; m_de = 0; m_se = 0; m_ss = 0; m_cnt = 0;
      end else begin
         bit w;
         w = bus_wr && bus_addr == 1;
         if (out_set) m_out = 1; else if (w && bus_wdata[6]) m_out = 0;
         if (se_set) m_se = 1; else if (w && bus_wdata[7]) m_se = 0;
         if (fs_set) m_fs = 1; else if (fs_clr) m_fs = 0;
         if (w) m_in = bus_wdata[1]; else if (in_done) m_in = 0;
         if (w) m_ss = bus_wdata[5]; else if (new_setup) m_ss = 0;
         if (w) m_de = bus_wdata[3]; else if (new_setup) m_de = 0;
         if (cnt_clr) m_cnt = 0; else if (cnt_inc && m_cnt < 7) m_cnt = m_cnt + 1;
      end
   end

   function automatic int exp_rdata(input int a);
      if (a == 1) return m_out + 2*m_in + 4*m_fs + 8*m_de + 16*m_se + 32*m_ss;
      if (a == 2) return m_cnt;
      return 0;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // inputs are already driven at a falling edge; compare, clock once, return to idle
   task automatic step(input string tag);
      #1;
      chk(tag, "rdata", bus_rdata, exp_rdata(bus_addr));
      chk(tag, "stall_req", stall_req, (m_ss | m_fs));
      chk(tag, "in_rdy", in_rdy, m_in);
      chk(tag, "data_end", data_end, m_de);
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0; out_set = 0; in_done = 0; fs_set = 0; fs_clr = 0;
      se_set = 0; new_setup = 0; cnt_inc = 0; cnt_clr = 0;
   endtask

   task automatic wr(input int a, input int d);
      bus_addr = a[3:0]; bus_wr = 1; bus_wdata = d[7:0];
   endtask

   task automatic rd(input int a, input string tag);
      bus_addr = a[3:0]; step(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state on both addresses
      rd(1, "R1"); rd(2, "R1");
      chk("R1", "stall_after_reset", stall_req, 0);

      // R3: out-ready set, direct write ignored, serviced clear
      out_set = 1; rd(1, "R3");
      rd(1, "R3");
      wr(1, 8'h01); step("R3");
      rd(1, "R3");
      wr(1, 8'h40); step("R3");
      rd(1, "R3");
      // R8: set and serviced clear together
      out_set = 1; wr(1, 8'h40); step("R8");
      rd(1, "R8");
      se_set = 1; wr(1, 8'h80); step("R8");
      rd(1, "R8");

      // R4: setup abort serviced, direct write ignored
      wr(1, 8'h10); step("R4");
      rd(1, "R4");
      wr(1, 8'h80); step("R4");
      rd(1, "R4");

      // R5: in-ready load, SIE clear, write wins
      wr(1, 8'h02); step("R5");
      rd(1, "R5");
      in_done = 1; bus_addr = 1; step("R5");
      rd(1, "R5");
      in_done = 1; wr(1, 8'h02); step("R5");
      rd(1, "R5");
      wr(1, 8'h00); step("R5");

      // R6: forced stall, bus writes ignored, set beats clear
      fs_set = 1; rd(1, "R6");
      wr(1, 8'h00); step("R6");
      rd(1, "R6");
      fs_clr = 1; rd(1, "R6");
      rd(1, "R6");
      fs_set = 1; fs_clr = 1; rd(1, "R6");
      rd(1, "R6");
      fs_clr = 1; rd(1, "R6");

      // R7 / R9: software stall and data end, new setup clears, write wins
      wr(1, 8'h28); step("R7");
      rd(1, "R9");
      new_setup = 1; rd(1, "R7");
      rd(1, "R7");
      wr(1, 8'h28); new_setup = 1; step("R7");
      rd(1, "R9");
      new_setup = 1; rd(1, "R7");

      // R10: saturating count, bus write ignored, clear beats increment
      for (int k = 0; k < 9; k++) begin cnt_inc = 1; rd(2, "R10"); end
      rd(2, "R10");
      wr(2, 8'h00); step("R10");
      rd(2, "R10");
      cnt_inc = 1; cnt_clr = 1; rd(2, "R10");
      rd(2, "R10");

      // R2: unmapped addresses and serviced bits read as zero
      rd(0, "R2"); rd(3, "R2");
      se_set = 1; out_set = 1; rd(1, "R2");
      wr(1, 8'hC0); step("R2");
      rd(1, "R2");

      // mixed random traffic, model compared every cycle
      for (int k = 0; k < 3000; k++) begin
         bus_addr  = 4'($urandom_range(0, 3));
         bus_wr    = ($urandom_range(0, 3) == 0);
         bus_wdata = 8'($urandom);
         out_set   = ($urandom_range(0, 4) == 0);
         in_done   = ($urandom_range(0, 4) == 0);
         fs_set    = ($urandom_range(0, 5) == 0);
         fs_clr    = ($urandom_range(0, 5) == 0);
         se_set    = ($urandom_range(0, 6) == 0);
         new_setup = ($urandom_range(0, 6) == 0);
         cnt_inc   = ($urandom_range(0, 1) == 0);
         cnt_clr   = ($urandom_range(0, 9) == 0);
         step("R8");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule